// File: doc/BRIEF.md
# TSB Probe Translation Walker

This block turns a virtual address into a physical address for a debug or functional access, and leaves all translation-buffer state untouched while it does so. A request carries the address, a hyperprivileged flag, an address-mask flag, a context-zero flag and the primary context. A hyperprivileged request is answered at once with the address unchanged. Any other request is first masked if asked, then shown on a lookup output (address and chosen context). An external TLB answers that lookup without updating its used bits. An external pointer generator supplies four TSB pointers in the same cycle.

If either TLB reports a hit, the physical address is built from that PTE. The data TLB wins over the instruction TLB. On a miss the walker reads the TSB tag words one at a time through a 64-bit memory read port. When a tag matches, it reads the data word that follows the tag and builds the address from it. If no tag matches, or if the PTE carries an illegal page-size code, the response reports an error.

Top module: `tsb_probe_walker`

## Requirements
- R1: A request accepted with `req_hpriv` high produces `resp_valid` on the next clock. It reports `resp_found`=1, `resp_err`=0 and `resp_paddr` equal to `req_vaddr` unchanged, even when `req_amask` is set. It issues no memory read.
- R2: With `req_amask` set on a request that is not hyperprivileged, bits 63:32 of the address are cleared before any lookup. `lkup_va` shows the cleared value, and the page offset in the result comes from it.
- R3: `lkup_ctx` is 0 when `req_ctx_zero` is set, and `req_pri_ctx` otherwise. It is valid from the cycle after acceptance.
- R4: The TLB inputs are sampled one cycle after acceptance, and the response follows one cycle later. When `dtlb_hit` is high, `dtlb_pte` is used even if `itlb_hit` is also high. On any TLB hit, no memory read is issued.
- R5: On a TLB miss, tag words are read from pointer 0, then 1, 2 and 3 in that order. Pointer k sits at `tsb_ptrs[64k+63:64k]`. The data word is read from the matching pointer + 8, and only after its tag matches.
- R6: Both memory words are big-endian: byte 0 of the value (bits 63:56) arrives in `mem_rsp_data[7:0]`.
- R7: A tag matches when its bit 62 is 0 and its bits 41:0 equal bits 63:22 of the (masked) virtual address.
- R8: The page-size code is {PTE[48], PTE[62:61]}. A code c below 6 selects a page of 8 KB × 8^c. The result is PTE[39:13]<<13 with the page-offset bits cleared, ORed with the virtual-address bits below the page size. It sets `resp_found`=1.
- R9: A PTE (from a TLB or the TSB) with size code 6 or 7 gives `resp_found`=0 and `resp_err`=1. `resp_found` and `resp_err` are never both set or both clear in a response.
- R10: If none of the four tags matches, the response has `resp_found`=0 and `resp_err`=1 after exactly four memory reads.
- R11: `req_ready` is low while a walk is in progress. A request raised then is ignored and produces no response.
- R12: While `mem_rd_valid` is high and `mem_rd_ready` is low, the request stays up and `mem_rd_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Walker idle |
| req_vaddr | input | 64 | Virtual address |
| req_hpriv | input | 1 | Hyperprivileged bypass |
| req_amask | input | 1 | Keep only the low 32 address bits |
| req_ctx_zero | input | 1 | Use context 0 for the lookup |
| req_pri_ctx | input | CTX_W | Primary context |
| lkup_va | output | 64 | Address presented to TLB and pointer generator |
| lkup_ctx | output | CTX_W | Context presented to TLB and pointer generator |
| dtlb_hit | input | 1 | Data TLB hit |
| dtlb_pte | input | 64 | Data TLB PTE |
| itlb_hit | input | 1 | Instruction TLB hit |
| itlb_pte | input | 64 | Instruction TLB PTE |
| tsb_ptrs | input | 64*NPROBE | TSB pointers, pointer k in slice k |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory read request accepted |
| mem_rd_addr | output | 64 | Memory read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, big-endian word |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 64 | Physical address |
| resp_found | output | 1 | Translation found |
| resp_err | output | 1 | No translation or illegal size code |

## Verification
The bench targets the first-match search. Tag 0 is valid except for its bit 62, tag 1 is valid but one address bit off, and tag 2 matches. A walker that ignores the invalid bit stops early, and one that compares the wrong field stops early or misses. Both cases show up in the read log and the result. A 256 MB page together with dual TLB hits catches a wrong split of the size code and a wrong TLB priority, because either error gives a different offset mask or frame. A stalling memory, a fully missing search, illegal size codes and a request raised mid-walk expose dropped or moving read requests, a missing error, and a stray second response.

// File: rtl/tsbw_pkg.sv
`timescale 1ns/1ps
package tsbw_pkg;
  typedef enum logic [2:0] {
    W_IDLE, W_LOOK, W_TREQ, W_TRSP, W_DREQ, W_DRSP
  } walk_st_t;

  function automatic logic [63:0] flip_bytes(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = w[8*(7-b) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/tsbw_tag_match.sv
`timescale 1ns/1ps
module tsbw_tag_match #(
  parameter int VA_LO = 22,
  parameter int INV_BIT = 62
) (
  input  logic             tag_inv,
  input  logic [63-VA_LO:0] tag_va,
  input  logic [63:0]      va,
  output logic             hit
);
  assign hit = !tag_inv && (tag_va == va[63:VA_LO]);
endmodule

// File: rtl/tsbw_pa_build.sv
`timescale 1ns/1ps
module tsbw_pa_build #(
  parameter int PG_BASE = 13,
  parameter int PG_STEP = 3,
  parameter int PA_HI = 39,
  parameter int NCODES = 6
) (
  input  logic [2:0]             code,
  input  logic [PA_HI:PG_BASE]   frame,
  input  logic [63:0]            va,
  output logic [63:0]            pa,
  output logic                   legal
);
  logic [6:0]  sh;
  logic [63:0] off_mask;
  logic [63:0] frame_full;

  always_comb begin
    legal      = ({29'd0, code} < 32'(NCODES));
    sh         = 7'(PG_BASE) + 7'(PG_STEP) * {4'd0, code};
    off_mask   = (64'd1 << sh) - 64'd1;
    frame_full = 64'(frame) << PG_BASE;
    pa         = (frame_full & ~off_mask) | (va & off_mask);
  end
endmodule

// File: rtl/tsb_probe_walker.sv
`timescale 1ns/1ps
module tsb_probe_walker
  import tsbw_pkg::*;
#(
  parameter int NPROBE = 4,
  parameter int CTX_W = 16,
  parameter int AMASK_W = 32,
  parameter int WORD_BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [63:0]          req_vaddr,
  input  logic                 req_hpriv,
  input  logic                 req_amask,
  input  logic                 req_ctx_zero,
  input  logic [CTX_W-1:0]     req_pri_ctx,
  output logic [63:0]          lkup_va,
  output logic [CTX_W-1:0]     lkup_ctx,
  input  logic                 dtlb_hit,
  input  logic [63:0]          dtlb_pte,
  input  logic                 itlb_hit,
  input  logic [63:0]          itlb_pte,
  input  logic [64*NPROBE-1:0] tsb_ptrs,
  output logic                 mem_rd_valid,
  input  logic                 mem_rd_ready,
  output logic [63:0]          mem_rd_addr,
  input  logic                 mem_rsp_valid,
  input  logic [63:0]          mem_rsp_data,
  output logic                 resp_valid,
  output logic [63:0]          resp_paddr,
  output logic                 resp_found,
  output logic                 resp_err
);
  localparam int PIDX_W = (NPROBE > 1) ? $clog2(NPROBE) : 1;
  localparam logic [PIDX_W-1:0] LAST_PROBE = PIDX_W'(NPROBE - 1);

  walk_st_t          st;
  logic [63:0]       va_q;
  logic [CTX_W-1:0]  ctx_q;
  logic [PIDX_W-1:0] probe_q;
  logic [63:0]       ptr_q [NPROBE];
  logic [63:0]       ptr_in [NPROBE];

  for (genvar k = 0; k < NPROBE; k++) begin : g_ptr
    assign ptr_in[k] = tsb_ptrs[64*k +: 64];
  end

  logic [63:0] rsp_word;
  logic [63:0] pte_mux;
  logic        tag_hit;
  logic [63:0] pa_built;
  logic        pa_legal;

  assign rsp_word = flip_bytes(mem_rsp_data);
  assign pte_mux  = (st == W_DRSP) ? rsp_word : (dtlb_hit ? dtlb_pte : itlb_pte);

  tsbw_tag_match #(.VA_LO(22), .INV_BIT(62)) u_tag (
    .tag_inv (rsp_word[62]),
    .tag_va  (rsp_word[41:0]),
    .va      (va_q),
    .hit     (tag_hit)
  );

  tsbw_pa_build #(.PG_BASE(13), .PG_STEP(3), .PA_HI(39), .NCODES(6)) u_pa (
    .code  ({pte_mux[48], pte_mux[62:61]}),
    .frame (pte_mux[39:13]),
    .va    (va_q),
    .pa    (pa_built),
    .legal (pa_legal)
  );

  assign req_ready    = (st == W_IDLE);
  assign lkup_va      = va_q;
  assign lkup_ctx     = ctx_q;
  assign mem_rd_valid = (st == W_TREQ) || (st == W_DREQ);
  assign mem_rd_addr  = ptr_q[probe_q] + ((st == W_DREQ) ? 64'(WORD_BYTES) : 64'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= W_IDLE;
      va_q       <= '0;
      ctx_q      <= '0;
      probe_q    <= '0;
      resp_valid <= 1'b0;
      resp_paddr <= '0;
      resp_found <= 1'b0;
      resp_err   <= 1'b0;
      for (int k = 0; k < NPROBE; k++) ptr_q[k] <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (st)
        W_IDLE: if (req_valid) begin
          if (req_hpriv) begin
            resp_valid <= 1'b1;
            resp_paddr <= req_vaddr;
            resp_found <= 1'b1;
            resp_err   <= 1'b0;
          end else begin
            va_q  <= req_amask ? {{(64-AMASK_W){1'b0}}, req_vaddr[AMASK_W-1:0]} : req_vaddr;
            ctx_q <= req_ctx_zero ? '0 : req_pri_ctx;
            st    <= W_LOOK;
          end
        end
        W_LOOK: begin
          for (int k = 0; k < NPROBE; k++) ptr_q[k] <= ptr_in[k];
          probe_q <= '0;
          if (dtlb_hit || itlb_hit) begin
            resp_valid <= 1'b1;
            resp_paddr <= pa_legal ? pa_built : 64'd0;
            resp_found <= pa_legal;
            resp_err   <= !pa_legal;
            st         <= W_IDLE;
          end else begin
            st <= W_TREQ;
          end
        end
        W_TREQ: if (mem_rd_ready) st <= W_TRSP;
        W_TRSP: if (mem_rsp_valid) begin
          if (tag_hit) begin
            st <= W_DREQ;
          end else if (probe_q == LAST_PROBE) begin
            resp_valid <= 1'b1;
            resp_paddr <= 64'd0;
            resp_found <= 1'b0;
            resp_err   <= 1'b1;
            st         <= W_IDLE;
          end else begin
            probe_q <= probe_q + 1'b1;
            st      <= W_TREQ;
          end
        end
        W_DREQ: if (mem_rd_ready) st <= W_DRSP;
        W_DRSP: if (mem_rsp_valid) begin
          resp_valid <= 1'b1;
          resp_paddr <= pa_legal ? pa_built : 64'd0;
          resp_found <= pa_legal;
          resp_err   <= !pa_legal;
          st         <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  p_hpriv_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && req_hpriv) |=>
      (resp_valid && resp_found && !resp_err && resp_paddr == $past(req_vaddr)));

  p_amask_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !req_hpriv && req_amask) |=> (lkup_va[63:AMASK_W] == '0));

  p_ctx_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (req_ready && req_valid && !req_hpriv && req_ctx_zero) |=> (lkup_ctx == '0));

  p_idle_no_read_r4: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_valid);

  p_found_xor_err_r9: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> (resp_found ^ resp_err));

  p_busy_no_ready_r11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready);

  p_read_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: tb/tb_tsb_probe_walker.sv
`timescale 1ns/1ps
module tb_tsb_probe_walker;
  localparam int NPROBE = 4;
  localparam int CTX_W = 16;
  localparam real CLK_HALF = 2.5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_HALF) clk = ~clk;

  logic req_valid = 1'b0, req_hpriv = 1'b0, req_amask = 1'b0, req_ctx_zero = 1'b0;
  logic req_ready;
  logic [63:0] req_vaddr = '0;
  logic [CTX_W-1:0] req_pri_ctx = '0;
  logic [63:0] lkup_va;
  logic [CTX_W-1:0] lkup_ctx;
  logic dtlb_hit = 1'b0, itlb_hit = 1'b0;
  logic [63:0] dtlb_pte = '0, itlb_pte = '0;
  logic [64*NPROBE-1:0] tsb_ptrs = '0;
  logic mem_rd_valid, mem_rd_ready, mem_rsp_valid;
  logic [63:0] mem_rd_addr, mem_rsp_data;
  logic resp_valid, resp_found, resp_err;
  logic [63:0] resp_paddr;

  tsb_probe_walker #(.NPROBE(NPROBE), .CTX_W(CTX_W)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_hpriv(req_hpriv), .req_amask(req_amask),
    .req_ctx_zero(req_ctx_zero), .req_pri_ctx(req_pri_ctx),
    .lkup_va(lkup_va), .lkup_ctx(lkup_ctx),
    .dtlb_hit(dtlb_hit), .dtlb_pte(dtlb_pte), .itlb_hit(itlb_hit), .itlb_pte(itlb_pte),
    .tsb_ptrs(tsb_ptrs), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_found(resp_found),
    .resp_err(resp_err)
  );

  // memory model
  logic [63:0] mem_a [16];
  logic [63:0] mem_d [16];
  int mem_n = 0;
  logic stall_en = 1'b0;
  logic rdy_q;
  logic rsp_v_q;
  logic [63:0] rsp_d_q;
  logic [63:0] rd_log [16];
  int rd_cnt = 0;
  int resp_cnt = 0;

  assign mem_rd_ready  = rdy_q;
  assign mem_rsp_valid = rsp_v_q;
  assign mem_rsp_data  = rsp_d_q;

  function automatic logic [63:0] mem_get(input logic [63:0] a);
    for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) return mem_d[i];
    return 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      rdy_q <= 1'b1; rsp_v_q <= 1'b0; rsp_d_q <= '0;
    end else begin
      rdy_q <= stall_en ? ~rdy_q : 1'b1;
      if (mem_rd_valid && rdy_q) begin
        rsp_v_q <= 1'b1;
        rsp_d_q <= mem_get(mem_rd_addr);
        rd_log[rd_cnt % 16] <= mem_rd_addr;
        rd_cnt <= rd_cnt + 1;
      end else begin
        rsp_v_q <= 1'b0;
      end
    end
    if (!rst && resp_valid) resp_cnt <= resp_cnt + 1;
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] be(input logic [63:0] x);
    return {<<8{x}};
  endfunction

  function automatic logic [63:0] mk_pte(input logic [2:0] code, input logic [39:0] frame);
    logic [63:0] p = '0;
    p[63] = 1'b1; p[62:61] = code[1:0]; p[48] = code[2]; p[39:13] = frame[39:13];
    return p;
  endfunction

  function automatic logic [63:0] mk_tag(input logic [63:0] va, input logic ok);
    logic [63:0] t = '0;
    t[62] = !ok; t[41:0] = va[63:22];
    return t;
  endfunction

  function automatic logic [63:0] exp_pa(input logic [63:0] pte, input logic [63:0] va);
    logic [2:0] c = {pte[48], pte[62:61]};
    logic [63:0] m = (64'd8192 << (3 * c)) - 64'd1;
    return ({24'd0, pte[39:13], 13'd0} & ~m) | (va & m);
  endfunction

  task automatic mem_put(input logic [63:0] a, input logic [63:0] v);
    mem_a[mem_n] = a; mem_d[mem_n] = be(v); mem_n++;
  endtask

  task automatic set_ptrs(input logic [63:0] p0, p1, p2, p3);
    tsb_ptrs = {p3, p2, p1, p0};
  endtask

  logic [63:0] got_pa, got_lva;
  logic got_found, got_err;
  logic [CTX_W-1:0] got_ctx;
  int got_cyc;

  task automatic run_req(input logic [63:0] va, input logic hp, am, cz, input logic [CTX_W-1:0] ctx);
    @(negedge clk);
    req_vaddr = va; req_hpriv = hp; req_amask = am; req_ctx_zero = cz; req_pri_ctx = ctx;
    req_valid = 1'b1;
    got_cyc = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      got_cyc++;
      if (i == 0) begin
        req_valid = 1'b0;
        got_lva = lkup_va; got_ctx = lkup_ctx;
      end
      if (resp_valid) begin
        got_pa = resp_paddr; got_found = resp_found; got_err = resp_err;
        return;
      end
    end
    got_found = 1'bx; got_err = 1'bx; got_pa = 'x;
  endtask

  task automatic t_reset;
    chk("R11 reset req_ready", {63'd0, req_ready}, 64'd1);
    chk("R9 reset resp_valid", {63'd0, resp_valid}, 64'd0);
    chk("R4 reset mem_rd_valid", {63'd0, mem_rd_valid}, 64'd0);
  endtask

  task automatic t_hpriv;
    int r0 = rd_cnt;
    run_req(64'hDEAD_BEEF_1234_5678, 1'b1, 1'b1, 1'b0, 16'h0005);
    chk("R1 hpriv paddr", got_pa, 64'hDEAD_BEEF_1234_5678);
    chk("R1 hpriv found/err", {62'd0, got_found, got_err}, 64'd2);
    chk("R1 hpriv latency", 64'(got_cyc), 64'd1);
    chk("R1 hpriv no reads", 64'(rd_cnt - r0), 64'd0);
  endtask

  task automatic t_dtlb;
    int r0 = rd_cnt;
    logic [63:0] va = 64'hFFFF_0000_0ABC_1234;
    logic [63:0] dp = mk_pte(3'd0, 40'hAB_CDEF_E000);
    dtlb_hit = 1'b1; dtlb_pte = dp;
    itlb_hit = 1'b1; itlb_pte = mk_pte(3'd3, 40'h11_2200_0000);
    run_req(va, 1'b0, 1'b1, 1'b0, 16'h0042);
    chk("R2 masked lkup_va", got_lva, 64'h0000_0000_0ABC_1234);
    chk("R3 primary ctx", 64'(got_ctx), 64'h42);
    chk("R4 dtlb priority paddr", got_pa, exp_pa(dp, 64'h0ABC_1234));
    chk("R4 tlb latency", 64'(got_cyc), 64'd2);
    chk("R4 tlb hit no reads", 64'(rd_cnt - r0), 64'd0);
    dtlb_hit = 1'b0; itlb_hit = 1'b0;
  endtask

  task automatic t_itlb;
    logic [63:0] va = 64'h0000_1234_5678_9ABC;
    logic [63:0] ip = mk_pte(3'd3, 40'h7F_FFFF_E000);
    itlb_hit = 1'b1; itlb_pte = ip;
    run_req(va, 1'b0, 1'b0, 1'b1, 16'h0077);
    chk("R3 ctx zero", 64'(got_ctx), 64'd0);
    chk("R8 itlb 4MB paddr", got_pa, exp_pa(ip, va));
    chk("R8 itlb found", {62'd0, got_found, got_err}, 64'd2);
    itlb_hit = 1'b0;
  endtask

  task automatic t_tsb_third;
    int r0 = rd_cnt;
    logic [63:0] va = 64'h0000_00A5_5ACE_0F0F;
    logic [63:0] good = mk_pte(3'd5, 40'h12_3450_0000);
    logic [63:0] bad_va = va ^ 64'h0000_0000_0040_0000;
    mem_n = 0;
    mem_put(64'h1000, mk_tag(va, 1'b0));
    mem_put(64'h1008, mk_pte(3'd0, 40'h99_0000_0000));
    mem_put(64'h2000, mk_tag(bad_va, 1'b1));
    mem_put(64'h2008, mk_pte(3'd0, 40'h88_0000_0000));
    mem_put(64'h3000, mk_tag(va, 1'b1));
    mem_put(64'h3008, good);
    set_ptrs(64'h1000, 64'h2000, 64'h3000, 64'h4000);
    stall_en = 1'b1;
    run_req(va, 1'b0, 1'b0, 1'b0, 16'h0009);
    stall_en = 1'b0;
    chk("R8 tsb 256MB paddr", got_pa, exp_pa(good, va));
    chk("R7 first match found", {62'd0, got_found, got_err}, 64'd2);
    chk("R5 read count", 64'(rd_cnt - r0), 64'd4);
    chk("R7 probe0 invalid tag read", rd_log[r0 % 16], 64'h1000);
    chk("R5 probe1 read", rd_log[(r0 + 1) % 16], 64'h2000);
    chk("R5 probe2 read", rd_log[(r0 + 2) % 16], 64'h3000);
    chk("R6 data word at +8", rd_log[(r0 + 3) % 16], 64'h3008);
  endtask

  task automatic t_tsb_miss;
    int r0 = rd_cnt;
    mem_n = 0;
    mem_put(64'h5000, mk_tag(64'h0000_0FFF_0000_0000, 1'b1));
    set_ptrs(64'h5000, 64'h6000, 64'h7000, 64'h8000);
    run_req(64'h0000_0001_0000_0000, 1'b0, 1'b0, 1'b0, 16'h0001);
    chk("R10 miss error", {62'd0, got_found, got_err}, 64'd1);
    chk("R10 four reads", 64'(rd_cnt - r0), 64'd4);
    chk("R10 last probe addr", rd_log[(r0 + 3) % 16], 64'h8000);
  endtask

  task automatic t_illegal;
    logic [63:0] va = 64'h0000_0000_8000_0000;
    mem_n = 0;
    mem_put(64'h9000, mk_tag(va, 1'b1));
    mem_put(64'h9008, mk_pte(3'd6, 40'h10_0000_0000));
    set_ptrs(64'h9000, 64'hA000, 64'hB000, 64'hC000);
    run_req(va, 1'b0, 1'b0, 1'b0, 16'h0003);
    chk("R9 tsb code 6 error", {62'd0, got_found, got_err}, 64'd1);
    dtlb_hit = 1'b1; dtlb_pte = mk_pte(3'd7, 40'h10_0000_0000);
    run_req(va, 1'b0, 1'b0, 1'b0, 16'h0003);
    chk("R9 tlb code 7 error", {62'd0, got_found, got_err}, 64'd1);
    dtlb_hit = 1'b0;
  endtask

  task automatic t_busy;
    int c0;
    logic [63:0] va = 64'h0000_0000_0000_2468;
    logic [63:0] pte = mk_pte(3'd1, 40'h55_5555_0000);
    mem_n = 0;
    mem_put(64'hD000, mk_tag(va, 1'b1));
    mem_put(64'hD008, pte);
    set_ptrs(64'hD000, 64'hE000, 64'hE100, 64'hE200);
    @(negedge clk);
    c0 = resp_cnt;
    req_vaddr = va; req_hpriv = 1'b0; req_amask = 1'b0; req_ctx_zero = 1'b0;
    req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 busy req_ready low", {63'd0, req_ready}, 64'd0);
    req_vaddr = 64'h1111_2222_3333_4444; req_hpriv = 1'b1; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0; req_hpriv = 1'b0;
    got_pa = 'x;
    for (int i = 0; i < 100; i++) begin
      if (resp_valid) begin got_pa = resp_paddr; break; end
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    chk("R11 walk result kept", got_pa, exp_pa(pte, va));
    chk("R11 single response", 64'(resp_cnt - c0), 64'd1);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_hpriv();
    t_dtlb();
    t_itlb();
    t_tsb_third();
    t_tsb_miss();
    t_illegal();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule